// File: doc/BRIEF.md
# Floppy Drive Head Positioning and Verify Sequencer

This block takes a floppy drive from idle to a head parked over a chosen track, and confirms the position at each step. A single `start` pulse captures a drive number, a head number and a track number. The block then writes the motor-on byte to the drive output control register and waits for the spindle to reach speed. Next it retracts the head to cylinder 0 and checks the result. After that it steps the head to the target track and checks again.

The disk controller reports nothing by itself after a recalibrate or a seek. For that reason each motion command is followed by a separate sense-interrupt-status command. The block reads back that command's status byte and present cylinder number and tests them bit by bit. A recalibrate that fails its test is repeated, up to a parameterised number of attempts in total. The block does not drive the controller's byte-level handshake itself. Each command byte written and each result byte read is handed to a transfer engine through a request/acknowledge pair, and that engine reports a timeout through an error strobe.

The outcome is given as a one-cycle `done` pulse, together with a `pass` flag and a two-bit error code. Both are held until the next start.

Top module: `head_seek_seq`

The FSM runs through the following states:
- `S_IDLE` goes to `S_MOTOR` on start.
- `S_MOTOR` (motor write) goes to `S_SPIN`.
- `S_SPIN` goes to `S_RECAL_TX` when the timer expires.
- `S_RECAL_TX` goes to `S_SETTLE` after its last byte.
- `S_SETTLE` goes to `S_SNSR_TX` when the timer expires.
- `S_SNSR_TX` goes to `S_SNSR_RX`.
- `S_SNSR_RX` goes to `S_RECAL_CHK`.
- `S_RECAL_CHK` goes to `S_SEEK_TX` on pass. On a fail it goes back to `S_RECAL_TX` (retry) or to `S_FINISH`.
- `S_SEEK_TX` goes to `S_SNSS_TX`.
- `S_SNSS_TX` goes to `S_SNSS_RX`.
- `S_SNSS_RX` goes to `S_SEEK_CHK`.
- `S_SEEK_CHK` goes to `S_FINISH`.
- `S_FINISH` goes to `S_IDLE`.

A transfer error in any of the TX or RX states goes straight to `S_FINISH`.

## Requirements
- R1: On an accepted start, `motor_wr` pulses for exactly one cycle with `motor_val` = (0x10 << drive) | drive | 0x0C. Drive 0 gives 0x1C, drive 1 gives 0x2D, drive 3 gives 0x8F.
- R2: No transfer request is raised until at least SPIN_CYC cycles after the motor write.
- R3: A transfer request holds `xfer_req`, `xfer_dir` (0 = write command byte, 1 = read result byte) and `xfer_wdata` steady until `xfer_ack` or `xfer_err` is seen. Bytes go out strictly in command order.
- R4: A recalibrate writes 0x07 and then the drive number. After at least SETTLE_CYC idle cycles, the block writes 0x08 and reads two bytes: the status byte first, then the cylinder.
- R5: A status check passes only when status bits 7, 6, 4 and 3 are 0 and bit 5 is 1. Bits 2..0 are ignored. The cylinder must also be 0 after a recalibrate, or the target track after a seek. A failed recalibrate check repeats the recalibrate and its sense.
- R6: After RECAL_TRIES failed recalibrate checks, the block finishes with `pass`=0 and `err_code`=2, and issues no seek.
- R7: A seek writes 0x0F, then head×4 + drive, then the track. It is followed by the 0x08 sense and two reads. A failed seek check finishes with `err_code`=3 and no retry.
- R8: An `xfer_err` strobe ends the run at once with `pass`=0 and `err_code`=1. No further request follows.
- R9: `done` is a one-cycle pulse. On success `pass`=1 and `err_code`=0. `pass` and `err_code` hold their values until the next accepted start.
- R10: A `start` while busy is ignored. Drive, head and track are sampled only when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a positioning run (accepted when idle) |
| drive | input | 2 | Drive number |
| head | input | 1 | Head number |
| track | input | 8 | Target track |
| motor_wr | output | 1 | Strobe to write the drive output control register |
| motor_val | output | 8 | Value for that register |
| xfer_req | output | 1 | Transfer request to the handshake engine |
| xfer_dir | output | 1 | 0 = write command byte, 1 = read result byte |
| xfer_wdata | output | 8 | Command byte to write |
| xfer_ack | input | 1 | Transfer completed (one cycle) |
| xfer_err | input | 1 | Transfer timed out (one cycle) |
| xfer_rdata | input | 8 | Result byte, valid with `xfer_ack` on a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run succeeded |
| err_code | output | 2 | 0 none, 1 transfer timeout, 2 recalibrate check, 3 seek check |

## Verification
The hardest paths to reach are the retry path and the exhaustion path. To reach them, the sense results after individual recalibrates must be wrong in different ways: a wrong cylinder, a stray bit 6, bit 4, bit 3 or bit 7, or a missing bit 5. The result of the following attempt must then be right or wrong as the test needs. The bench's transfer engine model serves read bytes from a scripted queue, one entry per read, so each recalibrate attempt gets its own status and cylinder. Timeout aborts are produced by having the engine answer one chosen transfer, counted from the start of the run, with the error strobe instead of an acknowledge.

// File: rtl/hss_pkg.sv
package hss_pkg;

    localparam int DRV_W = 2;

    localparam logic [7:0] OPC_RECAL = 8'h07;
    localparam logic [7:0] OPC_SENSE = 8'h08;
    localparam logic [7:0] OPC_SEEK  = 8'h0F;

    localparam logic [7:0] MOTOR_BASE = 8'h10;
    localparam logic [7:0] MOTOR_FIX  = 8'h0C;

    // status byte: bits 7..3 are checked, 2..0 ignored
    localparam logic [7:0] ST0_MASK = 8'hF8;
    localparam logic [7:0] ST0_WANT = 8'h20;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MOTOR,
        S_SPIN,
        S_RECAL_TX,
        S_SETTLE,
        S_SNSR_TX,
        S_SNSR_RX,
        S_RECAL_CHK,
        S_SEEK_TX,
        S_SNSS_TX,
        S_SNSS_RX,
        S_SEEK_CHK,
        S_FINISH
    } hss_state_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_XFER  = 2'd1,
        ERR_RECAL = 2'd2,
        ERR_SEEK  = 2'd3
    } hss_err_e;

endpackage

// File: rtl/hss_timer.sv
module hss_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    AST_TMR_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired); // R2

endmodule

// File: rtl/hss_verify.sv
module hss_verify (
    input  logic [7:0] st0,
    input  logic [7:0] cyl,
    input  logic [7:0] want_cyl,
    output logic       ok
);
    import hss_pkg::*;

    logic st_good;
    logic cyl_good;

    always_comb begin
        st_good  = ((st0 & ST0_MASK) == ST0_WANT);
        cyl_good = (cyl == want_cyl);
        ok       = st_good && cyl_good;
    end

endmodule

// File: rtl/head_seek_seq.sv
module head_seek_seq
    import hss_pkg::*;
#(
    parameter int SPIN_CYC    = 50_000_000,
    parameter int SETTLE_CYC  = 3_000_000,
    parameter int RECAL_TRIES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] drive,
    input  logic       head,
    input  logic [7:0] track,
    output logic       motor_wr,
    output logic [7:0] motor_val,
    output logic       xfer_req,
    output logic       xfer_dir,
    output logic [7:0] xfer_wdata,
    input  logic       xfer_ack,
    input  logic       xfer_err,
    input  logic [7:0] xfer_rdata,
    output logic       busy,
    output logic       done,
    output logic       pass,
    output logic [1:0] err_code
);
    localparam int MAX_DLY = (SPIN_CYC > SETTLE_CYC) ? SPIN_CYC : SETTLE_CYC;
    localparam int TMR_W   = $clog2(MAX_DLY + 1);
    localparam int ATT_W   = $clog2(RECAL_TRIES + 1);
    localparam logic [ATT_W-1:0] LAST_TRY = ATT_W'(RECAL_TRIES - 1);

    hss_state_e state, nxt;

    logic [DRV_W-1:0] drv_q;
    logic             head_q;
    logic [7:0]       trk_q;
    logic [1:0]       idx, idx_nxt;
    logic [ATT_W-1:0] attempt;
    logic [7:0]       st0_q, cyl_q;
    logic             pass_q;
    hss_err_e         err_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;

    logic             fin_pass;
    hss_err_e         fin_err;
    logic             cap_st0, cap_cyl;
    logic             att_inc;
    logic             chk_ok;
    logic [7:0]       chk_cyl;
    logic             xfer_done;

    hss_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign chk_cyl = (state == S_SEEK_CHK) ? trk_q : 8'h00;

    hss_verify u_verify (
        .st0      (st0_q),
        .cyl      (cyl_q),
        .want_cyl (chk_cyl),
        .ok       (chk_ok)
    );

    assign xfer_done = xfer_ack || xfer_err;

    // state register and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            drv_q   <= '0;
            head_q  <= 1'b0;
            trk_q   <= '0;
            idx     <= '0;
            attempt <= '0;
            st0_q   <= '0;
            cyl_q   <= '0;
            pass_q  <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            state <= nxt;
            idx   <= idx_nxt;
            if (state == S_IDLE && start) begin
                drv_q   <= drive;
                head_q  <= head;
                trk_q   <= track;
                attempt <= '0;
                pass_q  <= 1'b0;
                err_q   <= ERR_NONE;
            end
            if (att_inc) begin
                attempt <= attempt + 1'b1;
            end
            if (cap_st0) begin
                st0_q <= xfer_rdata;
            end
            if (cap_cyl) begin
                cyl_q <= xfer_rdata;
            end
            if (nxt == S_FINISH && state != S_FINISH) begin
                pass_q <= fin_pass;
                err_q  <= fin_err;
            end
        end
    end

    // next-state logic
    always_comb begin
        nxt      = state;
        idx_nxt  = idx;
        tmr_load = 1'b0;
        tmr_val  = '0;
        fin_pass = 1'b0;
        fin_err  = ERR_NONE;
        cap_st0  = 1'b0;
        cap_cyl  = 1'b0;
        att_inc  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    nxt = S_MOTOR;
                end
            end
            S_MOTOR: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(SPIN_CYC);
                nxt      = S_SPIN;
            end
            S_SPIN: begin
                if (tmr_expired) begin
                    nxt     = S_RECAL_TX;
                    idx_nxt = '0;
                end
            end
            S_RECAL_TX: begin
                if (xfer_err) begin
                    nxt     = S_FINISH;
                    fin_err = ERR_XFER;
                end else if (xfer_ack) begin
                    if (idx == 2'd1) begin
                        nxt      = S_SETTLE;
                        idx_nxt  = '0;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(SETTLE_CYC);
                    end else begin
                        idx_nxt = idx + 2'd1;
                    end
                end
            end
            S_SETTLE: begin
                if (tmr_expired) begin
                    nxt = S_SNSR_TX;
                end
            end
            S_SNSR_TX, S_SNSS_TX: begin
                if (xfer_err) begin
                    nxt     = S_FINISH;
                    fin_err = ERR_XFER;
                end else if (xfer_ack) begin
                    nxt     = (state == S_SNSR_TX) ? S_SNSR_RX : S_SNSS_RX;
                    idx_nxt = '0;
                end
            end
            S_SNSR_RX, S_SNSS_RX: begin
                if (xfer_err) begin
                    nxt     = S_FINISH;
                    fin_err = ERR_XFER;
                end else if (xfer_ack) begin
                    if (idx == 2'd0) begin
                        cap_st0 = 1'b1;
                        idx_nxt = 2'd1;
                    end else begin
                        cap_cyl = 1'b1;
                        idx_nxt = '0;
                        nxt     = (state == S_SNSR_RX) ? S_RECAL_CHK : S_SEEK_CHK;
                    end
                end
            end
            S_RECAL_CHK: begin
                if (chk_ok) begin
                    nxt     = S_SEEK_TX;
                    idx_nxt = '0;
                end else if (attempt == LAST_TRY) begin
                    nxt     = S_FINISH;
                    fin_err = ERR_RECAL;
                end else begin
                    att_inc = 1'b1;
                    nxt     = S_RECAL_TX;
                    idx_nxt = '0;
                end
            end
            S_SEEK_TX: begin
                if (xfer_err) begin
                    nxt     = S_FINISH;
                    fin_err = ERR_XFER;
                end else if (xfer_ack) begin
                    if (idx == 2'd2) begin
                        nxt     = S_SNSS_TX;
                        idx_nxt = '0;
                    end else begin
                        idx_nxt = idx + 2'd1;
                    end
                end
            end
            S_SEEK_CHK: begin
                nxt = S_FINISH;
                if (chk_ok) begin
                    fin_pass = 1'b1;
                end else begin
                    fin_err = ERR_SEEK;
                end
            end
            S_FINISH: begin
                nxt = S_IDLE;
            end
            default: begin
                nxt = S_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        motor_wr   = 1'b0;
        motor_val  = (MOTOR_BASE << drv_q) | {6'b0, drv_q} | MOTOR_FIX;
        xfer_req   = 1'b0;
        xfer_dir   = 1'b0;
        xfer_wdata = 8'h00;
        busy       = (state != S_IDLE);
        done       = (state == S_FINISH);
        pass       = pass_q;
        err_code   = err_q;
        unique case (state)
            S_MOTOR: begin
                motor_wr = 1'b1;
            end
            S_RECAL_TX: begin
                xfer_req   = 1'b1;
                xfer_wdata = (idx == 2'd0) ? OPC_RECAL : {6'b0, drv_q};
            end
            S_SNSR_TX, S_SNSS_TX: begin
                xfer_req   = 1'b1;
                xfer_wdata = OPC_SENSE;
            end
            S_SNSR_RX, S_SNSS_RX: begin
                xfer_req = 1'b1;
                xfer_dir = 1'b1;
            end
            S_SEEK_TX: begin
                xfer_req = 1'b1;
                unique case (idx)
                    2'd0:    xfer_wdata = OPC_SEEK;
                    2'd1:    xfer_wdata = {5'b0, head_q, drv_q};
                    default: xfer_wdata = trk_q;
                endcase
            end
            default: begin
            end
        endcase
    end

    AST_MOTOR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        motor_wr |-> (motor_val[3:2] == 2'b11) && ($countones(motor_val[7:4]) == 1)); // R1
    AST_MOTOR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        motor_wr |=> !motor_wr && !xfer_req); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> xfer_req && $stable(xfer_dir) && $stable(xfer_wdata)); // R3
    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        attempt < ATT_W'(RECAL_TRIES)); // R6
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !xfer_req && !motor_wr); // R8
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_err) |=> done && !pass && err_code == 2'd1); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> err_code == 2'd0); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(done)) |-> $stable(pass) && $stable(err_code)); // R9

endmodule

// File: tb/head_seek_seq_bench.sv
`timescale 1ns/1ps
module head_seek_seq_bench;

    localparam int SPIN   = 40;
    localparam int SETTLE = 12;
    localparam int TRIES  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] drive = '0;
    logic       head = 1'b0;
    logic [7:0] track = '0;
    logic       motor_wr;
    logic [7:0] motor_val;
    logic       xfer_req, xfer_dir;
    logic [7:0] xfer_wdata;
    logic       xfer_ack = 1'b0;
    logic       xfer_err = 1'b0;
    logic [7:0] xfer_rdata = '0;
    logic       busy, done, pass;
    logic [1:0] err_code;

    always #2.5 clk = ~clk;

    head_seek_seq #(
        .SPIN_CYC    (SPIN),
        .SETTLE_CYC  (SETTLE),
        .RECAL_TRIES (TRIES)
    ) u_head_seek_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .drive(drive), .head(head),
        .track(track), .motor_wr(motor_wr), .motor_val(motor_val),
        .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_wdata(xfer_wdata),
        .xfer_ack(xfer_ack), .xfer_err(xfer_err), .xfer_rdata(xfer_rdata),
        .busy(busy), .done(done), .pass(pass), .err_code(err_code)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // reference model state
    logic [7:0] exp_w[$];
    logic [7:0] resp[$];
    int   lat       = 0;
    int   err_at    = -1;
    int   xfer_n    = 0;
    int   wait_cnt  = 0;
    int   cyc       = 0;
    int   motor_cyc = 0;
    int   motor_cnt = 0;
    int   last_done = 0;
    bit   spin_pend = 0;
    bit   recal_end = 0;
    logic [7:0] exp_motor = '0;
    logic [7:0] last_w = '0;

    // per-clock model: transfer engine, monitors, watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
        if (rst_n) begin
            chk(!(xfer_req && !busy), "R8 req while idle", xfer_req, 0);
            if (motor_wr) begin
                motor_cnt++;
                motor_cyc = cyc;
                spin_pend = 1;
                chk(motor_val == exp_motor, "R1 motor value", motor_val, exp_motor);
            end
            if (xfer_ack || xfer_err) begin
                xfer_ack = 1'b0;
                xfer_err = 1'b0;
                last_done = cyc;
            end else if (xfer_req) begin
                if (spin_pend) begin
                    spin_pend = 0;
                    chk(cyc - motor_cyc >= SPIN, "R2 spin delay", cyc - motor_cyc, SPIN);
                end
                if (wait_cnt == 0 && recal_end && !xfer_dir) begin
                    recal_end = 0;
                    chk(cyc - last_done >= SETTLE, "R4 settle delay", cyc - last_done, SETTLE);
                end
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    if (!xfer_dir) begin
                        if (exp_w.size() == 0) begin
                            chk(1'b0, "R3 unexpected write", xfer_wdata, 0);
                        end else begin
                            logic [7:0] e;
                            e = exp_w.pop_front();
                            chk(xfer_wdata == e, "R3 command byte", xfer_wdata, e);
                        end
                        if (last_w == 8'h07) recal_end = 1;
                        last_w = xfer_wdata;
                    end else begin
                        xfer_rdata = (resp.size() != 0) ? resp.pop_front() : 8'hEE;
                    end
                    if (xfer_n == err_at) xfer_err = 1'b1;
                    else                  xfer_ack = 1'b1;
                    xfer_n++;
                end
            end
        end
    end

    task automatic q_recal(input logic [1:0] d, input logic [7:0] s, input logic [7:0] c);
        exp_w.push_back(8'h07); exp_w.push_back({6'b0, d}); exp_w.push_back(8'h08);
        resp.push_back(s); resp.push_back(c);
    endtask

    task automatic q_seek(input logic [1:0] d, input logic h, input logic [7:0] t,
                          input logic [7:0] s, input logic [7:0] c);
        exp_w.push_back(8'h0F); exp_w.push_back({5'b0, h, d}); exp_w.push_back(t);
        exp_w.push_back(8'h08);
        resp.push_back(s); resp.push_back(c);
    endtask

    task automatic run_case(input string name, input logic [1:0] d, input logic h,
                            input logic [7:0] t, input int l, input bit ep,
                            input logic [1:0] ee, input bit disturb);
        int n;
        lat = l; xfer_n = 0; wait_cnt = 0; motor_cnt = 0; last_w = '0; recal_end = 0;
        exp_motor = (8'h10 << d) | {6'b0, d} | 8'h0C;
        @(negedge clk);
        drive = d; head = h; track = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (5) @(negedge clk);
            drive = ~d; head = ~h; track = t + 8'd9; start = 1'b1;   // R10
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done, {name, " R9 done seen"}, done, 1);
        chk(pass == ep, {name, " R9 pass"}, pass, ep);
        chk(err_code == ee, {name, " R6 R7 R8 error code"}, err_code, ee);
        chk(exp_w.size() == 0, {name, " R3 R10 all bytes sent"}, exp_w.size(), 0);
        chk(resp.size() == 0, {name, " R4 all results read"}, resp.size(), 0);
        chk(motor_cnt == 1, {name, " R1 R10 single motor write"}, motor_cnt, 1);
        @(negedge clk);
        chk(!done, {name, " R9 done one cycle"}, done, 0);
        repeat (20) @(negedge clk);
        chk(!xfer_req && !busy, {name, " R8 quiet after end"}, xfer_req, 0);
        chk(pass == ep && err_code == ee, {name, " R9 result held"}, {pass, err_code}, {ep, ee});
        exp_w.delete(); resp.delete(); err_at = -1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !xfer_req && !motor_wr, "R9 reset state", busy, 0);
        chk(!pass && err_code == 2'd0, "R9 reset result", {pass, err_code}, 0);
        rst_n = 1'b1;

        // R5 R7: nominal, drive 0
        q_recal(2'd0, 8'h20, 8'h00); q_seek(2'd0, 1'b0, 8'd5, 8'h20, 8'd5);
        run_case("nominal", 2'd0, 1'b0, 8'd5, 1, 1'b1, 2'd0, 1'b0);

        // R5 low status bits ignored; R10 start while busy
        q_recal(2'd1, 8'h21, 8'h00); q_seek(2'd1, 1'b1, 8'd40, 8'h25, 8'd40);
        run_case("drive1", 2'd1, 1'b1, 8'd40, 3, 1'b1, 2'd0, 1'b1);

        // R5 two failed recal checks then success
        q_recal(2'd2, 8'h20, 8'h01); q_recal(2'd2, 8'h60, 8'h00); q_recal(2'd2, 8'h22, 8'h00);
        q_seek(2'd2, 1'b0, 8'd79, 8'h20, 8'd79);
        run_case("retry", 2'd2, 1'b0, 8'd79, 0, 1'b1, 2'd0, 1'b0);

        // R6 three failed recal checks
        q_recal(2'd3, 8'h30, 8'h00); q_recal(2'd3, 8'h28, 8'h00); q_recal(2'd3, 8'hA0, 8'h00);
        run_case("recal_fail", 2'd3, 1'b0, 8'd10, 2, 1'b0, 2'd2, 1'b0);

        // R6 missing bit 5 on every attempt
        q_recal(2'd0, 8'h00, 8'h00); q_recal(2'd0, 8'h00, 8'h00); q_recal(2'd0, 8'h00, 8'h00);
        run_case("no_bit5", 2'd0, 1'b1, 8'd1, 0, 1'b0, 2'd2, 1'b0);

        // R7 seek cylinder mismatch
        q_recal(2'd0, 8'h20, 8'h00); q_seek(2'd0, 1'b1, 8'd12, 8'h20, 8'd11);
        run_case("seek_cyl", 2'd0, 1'b1, 8'd12, 1, 1'b0, 2'd3, 1'b0);

        // R7 seek status bit 4
        q_recal(2'd1, 8'h20, 8'h00); q_seek(2'd1, 1'b0, 8'd3, 8'h30, 8'd3);
        run_case("seek_st", 2'd1, 1'b0, 8'd3, 0, 1'b0, 2'd3, 1'b0);

        // R8 timeout on first seek byte (transfer index 5)
        q_recal(2'd0, 8'h20, 8'h00); exp_w.push_back(8'h0F);
        err_at = 5;
        run_case("timeout", 2'd0, 1'b0, 8'd20, 1, 1'b0, 2'd1, 1'b0);

        // R8 timeout on a result read (transfer index 3)
        exp_w.push_back(8'h07); exp_w.push_back(8'h01); exp_w.push_back(8'h08);
        resp.push_back(8'h20);
        err_at = 3;
        run_case("timeout_rd", 2'd1, 1'b0, 8'd2, 0, 1'b0, 2'd1, 1'b0);

        // R9 clean pass clears previous error
        q_recal(2'd3, 8'h20, 8'h00); q_seek(2'd3, 1'b0, 8'd77, 8'h23, 8'd77);
        run_case("recover", 2'd3, 1'b0, 8'd77, 2, 1'b1, 2'd0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule